// File: doc/BRIEF.md
# Static memory turnaround gap controller

This block paces the transactions that a static memory bus sequencer runs, one after another. A request queue presents the next transaction on a valid/ready handshake. The descriptor gives the direction, whether the transfer is synchronous or asynchronous, the target bank, and a flag that marks the bank as one with a shared address/data bus or the extended shared-bus timing variant. The sequencer reports the last cycle of each transaction on `xfer_done`. The controller keeps a record of the transaction that just finished. When the next descriptor arrives, it works out how many idle cycles must separate the two. It raises `req_ready` only once that many cycles have gone by since the completion.

In most cases the gap is the programmed turnaround value plus one. A synchronous write is followed by a fixed gap of 2 or 3 cycles instead, whatever the programmed value. Some pairs need no gap at all. The state machine has three states:
- `ST_IDLE`: no write is pending, so the next request is accepted at once.
- `ST_BUSY`: a transaction has been accepted and is running.
- `ST_SETTLE`: a write has finished and the idle counter runs until the computed gap is met.

The transitions are:
- IDLE→BUSY and SETTLE→BUSY on an accepted request.
- BUSY→SETTLE when a write completes.
- BUSY→IDLE when a read completes.

Top module: `tgc_gap_ctrl`

## Requirements
Gap convention used below: if the earlier transaction completes in cycle c, a gap of G means the next request is accepted no earlier than cycle c+1+G. `turn_val` is an unsigned value T. "Async" means `req_sync`=0, "sync" means `req_sync`=1, "write" means `req_write`=1.
- R1: After reset `req_ready` is 1, and a valid request is accepted in the first cycle it is presented.
- R2: After an async write completes, any following read (sync or async, any bank) gets a gap of T+1.
- R3: After an async write completes, a write to a different bank, or a sync write to the same bank, gets a gap of T+1.
- R4: After an async write completes, an async write to the same bank gets a gap of 0 if the finished write had `req_shared`=0, and a gap of T+1 if it had `req_shared`=1.
- R5: After a sync write completes, any async transaction gets a gap of exactly 2.
- R6: After a sync write completes, a sync write gets a gap of exactly 2 to the same bank and exactly 3 to a different bank.
- R7: After a sync write completes, a sync read to any bank gets a gap of exactly 3.
- R8: After a read completes, the next request is accepted with a gap of 0.
- R9: T is sampled in the completion cycle. A value that changes there is the one used, and any later change has no effect on that gap.
- R10: Only one transaction is outstanding. `req_ready` is 0 from the cycle after acceptance up to and including the completion cycle. `xfer_done` is ignored while no transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turn_val | input | TURN_W | Programmed turnaround value T |
| req_valid | input | 1 | Next transaction descriptor is valid |
| req_ready | output | 1 | Next transaction may start (accepted when valid and ready) |
| req_sync | input | 1 | 1 = synchronous transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | clog2(BANKS) | Target bank |
| req_shared | input | 1 | Target bank uses a shared address/data bus or extended shared-bus timing |
| xfer_done | input | 1 | Last cycle of the outstanding transaction |

## Verification
Two events can fall in the same cycle and have to be tested together. The first pair is a completion and a new turnaround value. The bench changes `turn_val` in the very cycle `xfer_done` is high, then in the cycle after it. It judges the measured gap against T+1 of the value that was present at completion. The second pair is a completion and a request that is already waiting. A request is held valid through the whole busy period and the completion cycle, and `req_ready` must stay low until the cycle after `xfer_done`. A stray `xfer_done` during a running gap is also injected, and the gap must still be measured from the real completion.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_SETTLE = 2'd2
    } tgc_state_e;

    // Classification of one transaction as seen by the gap rule.
    typedef struct packed {
        logic sync;
        logic wr;
        logic shared;
    } tgc_kind_t;

endpackage

// File: rtl/tgc_gap_rule.sv
module tgc_gap_rule
    import tgc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int TURN_W = 4,
    parameter int CNT_W  = 5
) (
    input  tgc_kind_t           prev_kind,
    input  logic [BANK_W-1:0]   prev_bank,
    input  logic [TURN_W-1:0]   turn_cap,
    input  tgc_kind_t           next_kind,
    input  logic [BANK_W-1:0]   next_bank,
    output logic [CNT_W-1:0]    need
);

    localparam logic [CNT_W-1:0] FIX_SHORT = CNT_W'(2);
    localparam logic [CNT_W-1:0] FIX_LONG  = CNT_W'(3);

    logic               same_bank;
    logic [CNT_W-1:0]   programmed;

    assign same_bank  = (prev_bank == next_bank);
    assign programmed = CNT_W'(turn_cap) + CNT_W'(1);

    always_comb begin
        need = '0;
        if (!prev_kind.wr) begin
            need = '0;
        end else if (prev_kind.sync) begin
            // fixed gaps after a synchronous write
            if (!next_kind.sync) begin
                need = FIX_SHORT;
            end else if (next_kind.wr && same_bank) begin
                need = FIX_SHORT;
            end else begin
                need = FIX_LONG;
            end
        end else begin
            // asynchronous write: programmed gap except same-bank async write pairs
            if (next_kind.wr && !next_kind.sync && same_bank && !prev_kind.shared) begin
                need = '0;
            end else begin
                need = programmed;
            end
        end
    end

endmodule

// File: rtl/tgc_idle_counter.sv
module tgc_idle_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run && (count != CNT_TOP)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tgc_gap_ctrl.sv
module tgc_gap_ctrl
    import tgc_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int TURN_W = 4,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TURN_W-1:0] turn_val,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_sync,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_shared,
    input  logic              xfer_done
);

    // one bit above the turnaround width holds T+1 without wrapping
    localparam int CNT_W = TURN_W + 1;

    tgc_state_e         state_q, state_d;
    tgc_kind_t          req_kind, cur_kind_q, prev_kind_q;
    logic [BANK_W-1:0]  cur_bank_q, prev_bank_q;
    logic [TURN_W-1:0]  turn_cap_q;
    logic [CNT_W-1:0]   idle_cnt, gap_need;
    logic               accept, finish, gap_met;

    assign req_kind = '{sync: req_sync, wr: req_write, shared: req_shared};
    assign accept   = req_valid & req_ready;
    assign finish   = (state_q == ST_BUSY) & xfer_done;
    assign gap_met  = (idle_cnt >= gap_need);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_BUSY;
            ST_BUSY:   if (xfer_done) state_d = cur_kind_q.wr ? ST_SETTLE : ST_IDLE;
            ST_SETTLE: if (accept)    state_d = ST_BUSY;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_BUSY:   req_ready = 1'b0;
            ST_SETTLE: req_ready = gap_met;
            default:   req_ready = 1'b0;
        endcase
    end

    // transaction records and captured turnaround value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind_q  <= '0;
            cur_bank_q  <= '0;
            prev_kind_q <= '0;
            prev_bank_q <= '0;
            turn_cap_q  <= '1;
        end else begin
            if (accept) begin
                cur_kind_q <= req_kind;
                cur_bank_q <= req_bank;
            end
            if (finish) begin
                prev_kind_q <= cur_kind_q;
                prev_bank_q <= cur_bank_q;
                turn_cap_q  <= turn_val;
            end
        end
    end

    tgc_gap_rule #(
        .BANK_W (BANK_W),
        .TURN_W (TURN_W),
        .CNT_W  (CNT_W)
    ) u_rule (
        .prev_kind (prev_kind_q),
        .prev_bank (prev_bank_q),
        .turn_cap  (turn_cap_q),
        .next_kind (req_kind),
        .next_bank (req_bank),
        .need      (gap_need)
    );

    tgc_idle_counter #(
        .CNT_W (CNT_W)
    ) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (finish),
        .run   (state_q == ST_SETTLE),
        .count (idle_cnt)
    );

endmodule

// File: rtl/tgc_gap_checker.sv
module tgc_gap_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_write,
    input logic req_sync,
    input logic xfer_done
);

    logic       busy_c, seen_any, cur_wr, cur_sync, prev_wr, prev_sync;
    logic [5:0] idle_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c    <= 1'b0;
            seen_any  <= 1'b0;
            cur_wr    <= 1'b0;
            cur_sync  <= 1'b0;
            prev_wr   <= 1'b0;
            prev_sync <= 1'b0;
            idle_c    <= '0;
        end else if (!busy_c) begin
            if (req_valid && req_ready) begin
                busy_c   <= 1'b1;
                seen_any <= 1'b1;
                cur_wr   <= req_write;
                cur_sync <= req_sync;
            end else if (idle_c != 6'h3f) begin
                idle_c <= idle_c + 6'd1;
            end
        end else if (xfer_done) begin
            busy_c    <= 1'b0;
            prev_wr   <= cur_wr;
            prev_sync <= cur_sync;
            idle_c    <= '0;
        end
    end

    a_r1_free_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_any |-> req_ready);

    a_r10_blocked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_c |-> !req_ready);

    a_r10_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_read_then_free: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_c && xfer_done && !cur_wr) |=> req_ready);

    a_r6_sync_write_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_c && prev_wr && prev_sync && req_valid && req_ready) |-> (idle_c >= 6'd2));

    a_r2_async_write_read_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_c && prev_wr && !prev_sync && req_valid && req_ready && !req_write)
            |-> (idle_c >= 6'd1));

endmodule

bind tgc_gap_ctrl tgc_gap_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_sync  (req_sync),
    .xfer_done (xfer_done)
);

// File: tb/tgc_gap_ctrl_test.sv
module tgc_gap_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] turn_val = 4'd3;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_sync = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_bank = 2'd0;
    logic       req_shared = 1'b0;
    logic       xfer_done = 1'b0;

    int    n_checks = 0;
    int    n_err = 0;
    int    cyc = 0;
    int    done_cyc = 0;
    int    turn_on_done = -1;
    bit    last_rdy;
    string cur_tag = "R1";

    // behavioural reference state
    bit m_busy, m_have, m_pw, m_ps, m_psh, m_cw, m_cs, m_csh;
    int m_pb, m_cb, m_turn, m_idle;

    tgc_gap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .turn_val(turn_val), .req_valid(req_valid),
        .req_ready(req_ready), .req_sync(req_sync), .req_write(req_write),
        .req_bank(req_bank), .req_shared(req_shared), .xfer_done(xfer_done)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_gap(bit pw, bit ps, bit psh, int pb,
                                   bit nw, bit ns, int nb, int t);
        if (!pw) return 0;
        if (ps) begin
            if (ns && !nw) return 3;
            if (ns && nw && nb != pb) return 3;
            return 2;
        end
        if (!ns && nw && nb == pb && !psh) return 0;
        return t + 1;
    endfunction

    function automatic bit ref_ready();
        if (m_busy) return 1'b0;
        if (!m_have) return 1'b1;
        return m_idle >= ref_gap(m_pw, m_ps, m_psh, m_pb,
                                 req_write, req_sync, int'(req_bank), m_turn);
    endfunction

    // one clock: compare with the model, advance the model, wait for the next low phase
    task automatic step();
        bit exp;
        #1;
        exp = ref_ready();
        last_rdy = req_ready;
        check(req_ready === exp, cur_tag, int'(req_ready), int'(exp));
        if (!m_busy) begin
            if (req_valid && exp) begin
                m_busy = 1; m_cw = req_write; m_cs = req_sync;
                m_csh = req_shared; m_cb = int'(req_bank);
            end else if (m_idle < 1000) begin
                m_idle++;
            end
        end else if (xfer_done) begin
            m_busy = 0; m_idle = 0;
            if (m_cw) begin
                m_have = 1; m_pw = 1; m_ps = m_cs; m_psh = m_csh; m_pb = m_cb;
                m_turn = int'(turn_val);
            end else begin
                m_have = 0;
            end
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic xfer(bit s, bit w, int b, bit sh, int hold, int exp_gap, string tag);
        int guard = 0;
        int acc;
        cur_tag = tag;
        req_valid = 1; req_sync = s; req_write = w; req_bank = 2'(b); req_shared = sh;
        do begin
            step();
            guard++;
        end while (!last_rdy && guard < 200);
        acc = cyc - 1;
        if (exp_gap >= 0)
            check(acc - done_cyc - 1 == exp_gap, tag, acc - done_cyc - 1, exp_gap);
        req_valid = 0;
        repeat (hold) step();
        xfer_done = 1;
        if (turn_on_done >= 0) begin
            turn_val = 4'(turn_on_done);
            turn_on_done = -1;
        end
        done_cyc = cyc;
        step();
        xfer_done = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog (all requirements): actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: ready at once after reset, first request accepted immediately
        cur_tag = "R1";
        step();
        check(last_rdy == 1'b1, "R1", int'(last_rdy), 1);
        xfer(0, 1, 0, 0, 2, -1, "R1");
        xfer(0, 0, 0, 0, 1, 4, "R2");
        xfer(0, 1, 1, 0, 1, 0, "R8");
        xfer(1, 0, 2, 0, 1, 4, "R2");
        xfer(0, 1, 0, 0, 1, 0, "R8");
        xfer(0, 1, 1, 0, 1, 4, "R3");
        xfer(1, 1, 1, 0, 1, 4, "R3");
        xfer(0, 0, 1, 0, 1, 2, "R5");
        xfer(1, 1, 0, 0, 1, 0, "R8");
        xfer(0, 1, 3, 0, 1, 2, "R5");
        xfer(0, 1, 3, 0, 1, 0, "R4");
        xfer(0, 1, 3, 1, 1, 0, "R4");
        xfer(0, 1, 3, 0, 1, 4, "R4");
        xfer(0, 0, 3, 0, 1, 4, "R2");
        xfer(1, 1, 1, 0, 1, 0, "R8");
        xfer(1, 1, 1, 0, 1, 2, "R6");
        xfer(1, 1, 3, 0, 1, 3, "R6");
        xfer(1, 0, 3, 0, 1, 3, "R7");
        xfer(1, 1, 2, 0, 1, 0, "R8");
        xfer(1, 0, 0, 0, 1, 3, "R7");
        // R2 boundaries of the programmed value
        turn_val = 4'd0;
        xfer(0, 1, 0, 0, 1, 0, "R8");
        xfer(0, 0, 1, 0, 1, 1, "R2");
        turn_val = 4'd15;
        xfer(0, 1, 0, 0, 1, 0, "R8");
        xfer(0, 0, 0, 0, 1, 16, "R2");
        // R9: change after the completion cycle is ignored
        turn_val = 4'd2;
        xfer(0, 1, 1, 0, 1, 0, "R8");
        turn_val = 4'd9;
        xfer(1, 0, 1, 0, 1, 3, "R9");
        // R9: change in the completion cycle itself is used
        turn_on_done = 5;
        xfer(0, 1, 1, 0, 1, 0, "R8");
        xfer(0, 0, 2, 0, 1, 6, "R9");
        // R10: stray completion during a gap does not restart it
        turn_val = 4'd4;
        xfer(0, 1, 2, 0, 1, 0, "R8");
        cur_tag = "R10";
        xfer_done = 1;
        step();
        xfer_done = 0;
        xfer(0, 0, 2, 0, 1, 5, "R10");
        // R10: request held valid across the busy period and the completion cycle
        cur_tag = "R10";
        req_valid = 1; req_sync = 0; req_write = 0; req_bank = 2'd0; req_shared = 0;
        step();
        check(last_rdy == 1'b1, "R8", int'(last_rdy), 1);
        for (int i = 0; i < 3; i++) begin
            step();
            check(last_rdy == 1'b0, "R10", int'(last_rdy), 0);
        end
        xfer_done = 1;
        step();
        check(last_rdy == 1'b0, "R10", int'(last_rdy), 0);
        xfer_done = 0;
        step();
        check(last_rdy == 1'b1, "R10", int'(last_rdy), 1);
        req_valid = 0;
        repeat (2) step();
        xfer_done = 1;
        step();
        xfer_done = 0;
        repeat (2) step();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule